// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block produces the system reset for a small 8-bit microcontroller core and steps it through run, idle and power-down. Four sources can start a reset: power-on detection, a watchdog overflow strobe, a software reset strobe, and the synchronised external reset pin. The pin counts only after it has stayed high long enough. A watchdog or software request starts a fixed internal pulse, and that pulse also drives the pull-up on the reset pin. The reset output stays high while any source is still active. It is released only on a machine-cycle boundary.

The CPU sends idle and power-down requests as single-cycle strobes. Idle gates only the CPU clock, and any enabled pending interrupt wakes the core. Power-down stops the oscillator. From power-down the core wakes only on a reset, or on the external interrupt line when the wake enable input is set. After an interrupt wake from power-down, the oscillator enable rises first. Both clock enables stay low until a programmable stabilisation count has run out.

Top module: `rstpm_ctrl`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1, `rst_cause_o` is 0 (power-on), and all three clock enables are 1. Once `por_i` falls, reset is released on the 12th clock edge.
- R2: The pin reset starts only after `rst_pin_i` has been sampled high on 24 consecutive edges (two machine cycles of 12 clocks). A high run of 23 samples or fewer causes no reset.
- R3: A watchdog or software strobe drives `rst_pull_o` high for exactly 36 clocks (three machine cycles), starting in the cycle after the strobe.
- R4: A watchdog strobe asserts `core_rst_o` in the cycle after it, whatever level the reset pin has.
- R5: A software reset strobe has the same effect as a watchdog strobe.
- R6: `core_rst_o` stays high while the pin is qualified and while the internal pulse runs, whichever lasts longer. It falls only on a clock edge that closes a machine cycle.
- R7: `rst_cause_o` holds the last reset source: 0 = power-on, 1 = watchdog, 2 = software, 3 = pin. When several sources fire in the same cycle, the watchdog wins over software, and software wins over the pin.
- R8: In idle, `cpu_clk_en_o` is 0 and `per_clk_en_o` and `osc_en_o` are 1. Idle ends only when `irq_pend_i` is high, and `ext_irq_i` alone does not end it.
- R9: In power-down, all three enables are 0. `irq_pend_i` has no effect there, and neither does `ext_irq_i` while `pd_wake_en_i` is 0.
- R10: When `ext_irq_i` and `pd_wake_en_i` are both high in power-down, `osc_en_o` rises at once. The CPU and peripheral enables stay 0 for `stab_len_i`+1 cycles and then return to 1.
- R11: Any reset returns the controller to run mode from idle or power-down.
- R12: Idle and power-down strobes are ignored while reset is asserted and in any mode other than run. When both strobes arrive together in run, power-down is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on detect, synchronous active-high reset of the block |
| rst_pin_i | input | 1 | Synchronised level of the external reset pin |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| sw_rst_i | input | 1 | Software reset strobe |
| idle_req_i | input | 1 | CPU request to enter idle |
| pd_req_i | input | 1 | CPU request to enter power-down |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| ext_irq_i | input | 1 | External interrupt line |
| pd_wake_en_i | input | 1 | Allows the external interrupt to wake from power-down |
| stab_len_i | input | STAB_W | Oscillator stabilisation count used on wake |
| core_rst_o | output | 1 | System reset to the core |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator run enable |
| rst_pull_o | output | 1 | Reset-pin pull-up drive |
| rst_cause_o | output | 2 | Last reset cause |

## Verification
A wrong pin qualification count or machine-cycle phase shows up at `core_rst_o` within one machine cycle. The reset either rises one sample too early or too late, or it falls off the 12-clock boundary. A wrong pulse counter changes the width of `rst_pull_o`, and a cause priority fault shows on `rst_cause_o` in the cycle after a simultaneous strobe. A power-mode fault shows at the clock enables in the cycle after the request or wake event. A stabilisation count that is off by one shifts the CPU enable by one clock. A reference model in the bench is compared with every output on every clock, so any such fault is caught in the cycle where it first appears.

// File: rtl/rstpm_pkg.sv
package rstpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_DOWN = 2'd2,
    MODE_WAKE = 2'd3
  } pmode_t;

  typedef enum logic [1:0] {
    CAUSE_POWER = 2'd0,
    CAUSE_WDOG  = 2'd1,
    CAUSE_SOFT  = 2'd2,
    CAUSE_PIN   = 2'd3
  } rcause_t;
endpackage

// File: rtl/rstpm_mcycle.sv
module rstpm_mcycle #(
  parameter int OSC_PER_MC = 12
) (
  input  logic clk,
  input  logic por_i,
  output logic mc_tick_o
);
  localparam int PHW = $clog2(OSC_PER_MC);
  localparam logic [PHW-1:0] PH_LAST = PHW'(OSC_PER_MC - 1);

  logic [PHW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (por_i) phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else phase_q <= phase_q + PHW'(1);
  end

  assign mc_tick_o = (phase_q == PH_LAST);

  // machine-cycle strobe never fires on two adjacent clocks (R6)
  p_tick_gap_r6: assert property (@(posedge clk) disable iff (por_i)
    mc_tick_o |=> !mc_tick_o);
endmodule

// File: rtl/rstpm_src.sv
module rstpm_src
  import rstpm_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int PIN_MC     = 2,
  parameter int PULSE_MC   = 3
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       mc_tick_i,
  input  logic       pin_i,
  input  logic       wdt_i,
  input  logic       sw_i,
  output logic       core_rst_o,
  output logic       pull_o,
  output logic [1:0] cause_o
);
  localparam int PIN_QUAL  = OSC_PER_MC * PIN_MC;
  localparam int PULSE_LEN = OSC_PER_MC * PULSE_MC;
  localparam int PW = $clog2(PIN_QUAL + 1);
  localparam int UW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PIN_FULL  = PW'(PIN_QUAL);
  localparam logic [PW-1:0] PIN_LAST  = PW'(PIN_QUAL - 1);
  localparam logic [UW-1:0] PULSE_TOP = UW'(PULSE_LEN);

  logic [PW-1:0] pin_cnt_q;
  logic [UW-1:0] pulse_q;
  logic          rst_q;
  rcause_t       cause_q;

  logic pin_hold, pin_event, int_trig, any_active;

  always_comb begin
    pin_hold   = (pin_cnt_q == PIN_FULL);
    pin_event  = pin_i && (pin_cnt_q == PIN_LAST);
    int_trig   = wdt_i || sw_i;
    any_active = pin_hold || (pulse_q != '0) || int_trig;
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      pin_cnt_q <= '0;
      pulse_q   <= '0;
      rst_q     <= 1'b1;
      cause_q   <= CAUSE_POWER;
    end else begin
      if (!pin_i)        pin_cnt_q <= '0;
      else if (!pin_hold) pin_cnt_q <= pin_cnt_q + PW'(1);

      if (int_trig)            pulse_q <= PULSE_TOP;
      else if (pulse_q != '0)  pulse_q <= pulse_q - UW'(1);

      rst_q <= any_active || (rst_q && !mc_tick_i);

      if (wdt_i)          cause_q <= CAUSE_WDOG;
      else if (sw_i)      cause_q <= CAUSE_SOFT;
      else if (pin_event) cause_q <= CAUSE_PIN;
    end
  end

  assign core_rst_o = rst_q;
  assign pull_o     = (pulse_q != '0);
  assign cause_o    = cause_q;

  // pull-up pulse always lies inside the reset window (R4)
  p_pull_in_rst_r4: assert property (@(posedge clk) disable iff (por_i)
    pull_o |-> core_rst_o);
  // release only at a machine-cycle boundary (R6)
  p_rel_boundary_r6: assert property (@(posedge clk) disable iff (por_i)
    $fell(core_rst_o) |-> $past(mc_tick_i));
  // a reset not started internally needs the pin high beforehand (R2)
  p_pin_origin_r2: assert property (@(posedge clk) disable iff (por_i)
    ($rose(core_rst_o) && !$past(wdt_i || sw_i)) |-> $past(pin_i, 2));
  // watchdog always wins the cause register (R7)
  p_cause_wdog_r7: assert property (@(posedge clk) disable iff (por_i)
    wdt_i |=> (cause_o == CAUSE_WDOG));
endmodule

// File: rtl/rstpm_pwr.sv
module rstpm_pwr
  import rstpm_pkg::*;
#(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              core_rst_i,
  input  logic              idle_req_i,
  input  logic              pd_req_i,
  input  logic              irq_pend_i,
  input  logic              ext_irq_i,
  input  logic              wake_en_i,
  input  logic [STAB_W-1:0] stab_len_i,
  output logic              cpu_en_o,
  output logic              per_en_o,
  output logic              osc_en_o
);
  pmode_t            state_q, state_d;
  logic [STAB_W-1:0] stab_q, stab_d;

  always_comb begin
    state_d = state_q;
    stab_d  = stab_q;
    if (core_rst_i) begin
      state_d = MODE_RUN;
    end else begin
      unique case (state_q)
        MODE_RUN: begin
          if (pd_req_i)        state_d = MODE_DOWN;
          else if (idle_req_i) state_d = MODE_IDLE;
        end
        MODE_IDLE: if (irq_pend_i) state_d = MODE_RUN;
        MODE_DOWN: begin
          if (ext_irq_i && wake_en_i) begin
            state_d = MODE_WAKE;
            stab_d  = stab_len_i;
          end
        end
        MODE_WAKE: begin
          if (stab_q == '0) state_d = MODE_RUN;
          else              stab_d  = stab_q - STAB_W'(1);
        end
        default: state_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      state_q  <= MODE_RUN;
      stab_q   <= '0;
      cpu_en_o <= 1'b1;
      per_en_o <= 1'b1;
      osc_en_o <= 1'b1;
    end else begin
      state_q  <= state_d;
      stab_q   <= stab_d;
      cpu_en_o <= (state_d == MODE_RUN);
      per_en_o <= (state_d == MODE_RUN) || (state_d == MODE_IDLE);
      osc_en_o <= (state_d != MODE_DOWN);
    end
  end

  // reset always returns the core to run (R11)
  p_rst_run_r11: assert property (@(posedge clk) disable iff (por_i)
    core_rst_i |=> (cpu_en_o && per_en_o && osc_en_o));
  // idle holds without a pending interrupt (R8)
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (por_i)
    (state_q == MODE_IDLE && !core_rst_i && !irq_pend_i) |=> (!cpu_en_o && per_en_o));
  // power-down holds without an enabled external wake (R9)
  p_down_hold_r9: assert property (@(posedge clk) disable iff (por_i)
    (state_q == MODE_DOWN && !core_rst_i && !(ext_irq_i && wake_en_i)) |=> !osc_en_o);
  // clocks stay gated while the stabilisation count runs (R10)
  p_wake_gate_r10: assert property (@(posedge clk) disable iff (por_i)
    (state_q == MODE_WAKE && stab_q != '0 && !core_rst_i) |=> (!cpu_en_o && osc_en_o));
endmodule

// File: rtl/rstpm_ctrl.sv
module rstpm_ctrl #(
  parameter int OSC_PER_MC = 12,
  parameter int PIN_MC     = 2,
  parameter int PULSE_MC   = 3,
  parameter int STAB_W     = 8
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              rst_pin_i,
  input  logic              wdt_ovf_i,
  input  logic              sw_rst_i,
  input  logic              idle_req_i,
  input  logic              pd_req_i,
  input  logic              irq_pend_i,
  input  logic              ext_irq_i,
  input  logic              pd_wake_en_i,
  input  logic [STAB_W-1:0] stab_len_i,
  output logic              core_rst_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              osc_en_o,
  output logic              rst_pull_o,
  output logic [1:0]        rst_cause_o
);
  logic mc_tick;

  rstpm_mcycle #(.OSC_PER_MC(OSC_PER_MC)) u_mcycle (
    .clk      (clk),
    .por_i    (por_i),
    .mc_tick_o(mc_tick)
  );

  rstpm_src #(
    .OSC_PER_MC(OSC_PER_MC),
    .PIN_MC    (PIN_MC),
    .PULSE_MC  (PULSE_MC)
  ) u_src (
    .clk       (clk),
    .por_i     (por_i),
    .mc_tick_i (mc_tick),
    .pin_i     (rst_pin_i),
    .wdt_i     (wdt_ovf_i),
    .sw_i      (sw_rst_i),
    .core_rst_o(core_rst_o),
    .pull_o    (rst_pull_o),
    .cause_o   (rst_cause_o)
  );

  rstpm_pwr #(.STAB_W(STAB_W)) u_pwr (
    .clk       (clk),
    .por_i     (por_i),
    .core_rst_i(core_rst_o),
    .idle_req_i(idle_req_i),
    .pd_req_i  (pd_req_i),
    .irq_pend_i(irq_pend_i),
    .ext_irq_i (ext_irq_i),
    .wake_en_i (pd_wake_en_i),
    .stab_len_i(stab_len_i),
    .cpu_en_o  (cpu_clk_en_o),
    .per_en_o  (per_clk_en_o),
    .osc_en_o  (osc_en_o)
  );
endmodule

// File: tb/rstpm_ctrl_test.sv
`timescale 1ns/1ps
module rstpm_ctrl_test;
  logic clk = 1'b0;
  logic por = 1'b1, pin = 1'b0, wdt = 1'b0, sw = 1'b0, idle = 1'b0, pd = 1'b0;
  logic irq = 1'b0, ext = 1'b0, wen = 1'b0;
  logic [7:0] stab = 8'd5;
  logic rst_o, cpu_o, per_o, osc_o, pull_o;
  logic [1:0] cause_o;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rstpm_ctrl uut (
    .clk(clk), .por_i(por), .rst_pin_i(pin), .wdt_ovf_i(wdt), .sw_rst_i(sw),
    .idle_req_i(idle), .pd_req_i(pd), .irq_pend_i(irq), .ext_irq_i(ext),
    .pd_wake_en_i(wen), .stab_len_i(stab),
    .core_rst_o(rst_o), .cpu_clk_en_o(cpu_o), .per_clk_en_o(per_o),
    .osc_en_o(osc_o), .rst_pull_o(pull_o), .rst_cause_o(cause_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: modes 0 run, 1 idle, 2 down, 3 waking
  int m_phase = 0, m_pin = 0, m_pulse = 0, m_rst = 1, m_cause = 0;
  int m_mode = 0, m_stab = 0;
  bit started = 0;

  always @(posedge clk) begin
    int n_mode, n_stab, n_rst, n_cause;
    bit tick, active;
    started = 1;
    if (por) begin
      m_phase = 0; m_pin = 0; m_pulse = 0; m_rst = 1; m_cause = 0;
      m_mode = 0; m_stab = 0;
    end else begin
      tick   = (m_phase == 11);
      active = (m_pin == 24) || (m_pulse > 0) || wdt || sw;
      n_rst  = (active || (m_rst == 1 && !tick)) ? 1 : 0;
      n_cause = wdt ? 1 : sw ? 2 : (pin && m_pin == 23) ? 3 : m_cause;
      n_mode = m_mode; n_stab = m_stab;
      if (m_rst == 1) n_mode = 0;
      else if (m_mode == 0) begin
        if (pd) n_mode = 2; else if (idle) n_mode = 1;
      end else if (m_mode == 1) begin
        if (irq) n_mode = 0;
      end else if (m_mode == 2) begin
        if (ext && wen) begin n_mode = 3; n_stab = stab; end
      end else begin
        if (m_stab == 0) n_mode = 0; else n_stab = m_stab - 1;
      end
      m_phase = tick ? 0 : m_phase + 1;
      m_pulse = (wdt || sw) ? 36 : (m_pulse > 0 ? m_pulse - 1 : 0);
      m_pin   = pin ? (m_pin < 24 ? m_pin + 1 : 24) : 0;
      m_rst = n_rst; m_cause = n_cause; m_mode = n_mode; m_stab = n_stab;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R6 core_rst model", int'(rst_o), m_rst);
      chk("R3 pull model", int'(pull_o), (m_pulse > 0) ? 1 : 0);
      chk("R7 cause model", int'(cause_o), m_cause);
      chk("R8 cpu_en model", int'(cpu_o), (m_mode == 0) ? 1 : 0);
      chk("R9 per_en model", int'(per_o), (m_mode <= 1) ? 1 : 0);
      chk("R10 osc_en model", int'(osc_o), (m_mode != 2) ? 1 : 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rel();
    while (rst_o) @(negedge clk);
  endtask

  task automatic pulse_sig(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  int cnt;

  initial begin
    step(5);
    chk("R1 rst in por", int'(rst_o), 1);
    chk("R1 cause power-on", int'(cause_o), 0);
    chk("R1 cpu_en in por", int'(cpu_o), 1);
    por = 1'b0;
    step(11);
    chk("R6 still held before boundary", int'(rst_o), 1);
    step(1);
    chk("R1 released at 12th edge", int'(rst_o), 0);

    pin = 1'b1; step(23); pin = 1'b0; step(5);
    chk("R2 short pin ignored", int'(rst_o), 0);

    pin = 1'b1; step(80);
    chk("R2 qualified pin reset", int'(rst_o), 1);
    chk("R6 held while pin high", int'(rst_o), 1);
    chk("R7 cause pin", int'(cause_o), 3);
    pin = 1'b0; wait_rel(); step(3);

    pin = 1'b1; wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    chk("R4 wdt resets with pin high", int'(rst_o), 1);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      if (i == 5) pin = 1'b0;
      if (pull_o) cnt++;
      @(negedge clk);
    end
    chk("R3 wdt pull width", cnt, 36);
    chk("R7 cause wdt", int'(cause_o), 1);
    wait_rel(); step(2);

    pulse_sig(sw);
    chk("R5 sw reset asserted", int'(rst_o), 1);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      if (pull_o) cnt++;
      @(negedge clk);
    end
    chk("R5 sw pull width", cnt, 36);
    chk("R7 cause sw", int'(cause_o), 2);
    wait_rel(); step(2);

    wdt = 1'b1; sw = 1'b1; @(negedge clk); wdt = 1'b0; sw = 1'b0;
    chk("R7 wdt beats sw", int'(cause_o), 1);
    wait_rel(); step(2);

    pulse_sig(idle);
    chk("R8 idle cpu gated", int'(cpu_o), 0);
    chk("R8 idle per on", int'(per_o), 1);
    chk("R8 idle osc on", int'(osc_o), 1);
    pulse_sig(ext); step(1);
    chk("R8 ext alone ignored in idle", int'(cpu_o), 0);
    pulse_sig(pd); step(1);
    chk("R12 pd ignored in idle", int'(osc_o), 1);
    pulse_sig(irq);
    chk("R8 irq wakes idle", int'(cpu_o), 1);

    idle = 1'b1; pd = 1'b1; @(negedge clk); idle = 1'b0; pd = 1'b0;
    chk("R12 pd wins over idle", int'(osc_o), 0);
    chk("R9 down cpu off", int'(cpu_o), 0);
    chk("R9 down per off", int'(per_o), 0);
    pulse_sig(irq); step(1);
    chk("R9 irq ignored in down", int'(osc_o), 0);
    wen = 1'b0; pulse_sig(ext); step(1);
    chk("R9 ext without enable ignored", int'(osc_o), 0);
    wen = 1'b1; stab = 8'd5; pulse_sig(ext);
    chk("R10 osc up on wake", int'(osc_o), 1);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (!cpu_o) cnt++;
      @(negedge clk);
    end
    chk("R10 stabilisation cycles", cnt, 6);
    chk("R10 cpu back on", int'(cpu_o), 1);

    pulse_sig(idle); step(2);
    pulse_sig(wdt); wait_rel(); step(1);
    chk("R11 reset exits idle", int'(cpu_o), 1);
    pulse_sig(pd); step(2);
    pin = 1'b1; step(30); pin = 1'b0; wait_rel(); step(1);
    chk("R11 pin reset exits down", int'(osc_o), 1);
    chk("R11 cpu after down reset", int'(cpu_o), 1);

    pulse_sig(sw);
    pulse_sig(idle);
    wait_rel(); step(2);
    chk("R12 idle during reset ignored", int'(cpu_o), 1);

    step(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL timeout all requirements actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule